// File: doc/BRIEF.md
# Sound-Generator Bus Write Bridge

This block lets an 8-bit processor with a 16-bit address bus write to a write-only sound generator as if it were a memory location. It watches the address, the read/write line, the valid-address qualifier and the second clock phase. It produces the active-low chip select and write strobe that the sound generator expects. A data register holds the last written byte on the generator's data pins, so those pins stay steady between writes.

The generator occupies a 512-byte window starting at 0x2000, with the nine low address bits ignored. Every address in that window reaches the generator as a mirror, so no other device may be placed there. The top address bit alone is not a valid select: it would also hit RAM or the ROM, keypad and display area. While the generator reports that it is not ready, the bridge pulls the processor's memory-ready line low to stretch the bus cycle. It releases that line once the generator is ready again.

All outputs are registered on the system clock. They follow the bus inputs seen at the previous rising edge.

Top module: `sndbus_wr_bridge`

## Requirements
- R1: A synchronous active-low reset drives `snd_ce_n` and `snd_we_n` high, clears `snd_data` to 0x00 and drives `cpu_mem_ready` high, whatever the bus inputs are.
- R2: `snd_ce_n` goes low one clock after an edge that sees `cpu_vma`=1 and `cpu_phi2`=1 with `cpu_addr` in 0x2000..0x21FF. Bits 8..0 are ignored, so every address in that range selects the generator.
- R3: `snd_ce_n` stays high after any edge that sees `cpu_vma`=0 or `cpu_phi2`=0, even when the address is inside the window.
- R4: `snd_ce_n` stays high for qualified accesses outside 0x2000..0x21FF, including addresses that share only bit 15, bit 13 or the neighbouring pages (0x8000, 0xA000, 0x1FFF, 0x2200, 0x0000, 0xFFFF).
- R5: `snd_we_n` goes low one clock after a selected access with `cpu_rw`=0 (write). It stays high after a selected access with `cpu_rw`=1 (read), and it is never low while `snd_ce_n` is high.
- R6: `snd_data` takes `cpu_wdata` one clock after a selected write. Reads, unqualified accesses and out-of-window accesses leave it unchanged.
- R7: `cpu_mem_ready` goes low on the same clock as `snd_ce_n` when the selecting edge sees `snd_ready`=0. It stays low as long as the selected access continues with `snd_ready`=0.
- R8: `cpu_mem_ready` is high one clock after an edge that sees `snd_ready`=1 or no selected access. It is therefore high whenever the bridge is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw | input | 1 | Bus direction: 1 read, 0 write |
| cpu_vma | input | 1 | Address valid qualifier, active high |
| cpu_phi2 | input | 1 | Second clock phase, high during data transfer |
| cpu_wdata | input | 8 | Processor write data |
| snd_ready | input | 1 | Sound generator ready, high when it can take a write |
| snd_ce_n | output | 1 | Sound generator chip select, active low |
| snd_we_n | output | 1 | Sound generator write strobe, active low |
| snd_data | output | 8 | Latched data toward the sound generator |
| cpu_mem_ready | output | 1 | Memory-ready to the processor clock stage, low stretches the cycle |

## Verification
Every output passes through exactly one register, so each result is due one rising edge after the bus inputs that cause it. This holds for select, write strobe, data latch and memory-ready release alike. The bench changes inputs on the falling edge and reads outputs on the next falling edge, half a cycle after the register has updated. Reset is checked the same way: one edge after `rst_n` is taken low. The stretch test keeps the access selected for several cycles with the ready input low and checks memory-ready on each one. It then raises ready and expects memory-ready high exactly one edge later.

// File: rtl/sndbus_pkg.sv
// Package: sndbus_pkg
// Types shared by the sound-generator bus bridge. An access descriptor
// carries the qualified decode result from the decoder to the registers.
package sndbus_pkg;

    // Qualified decode result for one sampled bus state.
    typedef struct packed {
        logic hit;   // qualified access inside the peripheral window
        logic wr;    // that access is a write
    } snd_acc_t;

    // Bus direction encoding of the processor read/write line.
    localparam logic BUS_READ  = 1'b1;
    localparam logic BUS_WRITE = 1'b0;

endpackage

// File: rtl/sndbus_addr_match.sv
// Module: sndbus_addr_match
// Combinational decode of the processor bus. It flags a qualified access
// when the address lies in the window BASE..BASE+2**IGNORE_BITS-1. A
// qualified access also needs the valid-address flag and the second clock
// phase to be high. The ignored low bits make every address in the window a
// mirror.
// Assumes: BASE is aligned to 2**IGNORE_BITS, IGNORE_BITS < ADDR_W.
module sndbus_addr_match
    import sndbus_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned IGNORE_BITS = 9,
    parameter logic [ADDR_W-1:0] BASE  = 16'h2000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              vma,
    input  logic              phi2,
    output snd_acc_t          acc
);

    logic in_window;
    logic qualified;

    // Choose the compare form: full-width match or masked match.
    generate
        if (IGNORE_BITS == 0) begin : g_full_cmp
            // Compare every address bit when nothing is ignored.
            always_comb in_window = (addr == BASE);
        end else begin : g_masked_cmp
            localparam logic [ADDR_W-1:0] LOW_ONES =
                ADDR_W'((64'd1 << IGNORE_BITS) - 64'd1);
            localparam logic [ADDR_W-1:0] KEEP_MASK = ~LOW_ONES;
            // Compare only the kept upper bits against the base.
            always_comb in_window = (((addr ^ BASE) & KEEP_MASK) == '0);
        end
    endgenerate

    // An address match counts only with a valid address in phase two.
    always_comb qualified = vma & phi2;

    // Build the descriptor passed to the registered stages.
    always_comb begin
        acc.hit = in_window & qualified;
        acc.wr  = in_window & qualified & (rw == BUS_WRITE);
    end

endmodule

// File: rtl/sndbus_strobe_gen.sv
// Module: sndbus_strobe_gen
// Registers the active-low chip select and write strobe toward the sound
// generator from the decode descriptor. The write strobe can fall only
// together with the select, because a read never raises the write flag.
// Assumes: synchronous active-low reset, outputs idle high.
module sndbus_strobe_gen
    import sndbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  snd_acc_t acc,
    output logic     ce_n,
    output logic     we_n
);

    // Register both strobes; reset parks them inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n <= 1'b1;
            we_n <= 1'b1;
        end else begin
            ce_n <= ~acc.hit;
            we_n <= ~(acc.hit & acc.wr);
        end
    end

endmodule

// File: rtl/sndbus_ready_stretch.sv
// Module: sndbus_ready_stretch
// Drives the processor's memory-ready line. It falls on the same edge as the
// select when the generator is not ready. It stays low while the selected
// access continues without ready, and it rises one edge after ready returns.
// Assumes: peripheral ready is synchronous to clk or already synchronised.
module sndbus_ready_stretch
    import sndbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  snd_acc_t acc,
    input  logic     per_ready,
    output logic     mem_ready
);

    logic stall_req;

    // A stall is wanted only for a selected access with the peripheral busy.
    always_comb stall_req = acc.hit & ~per_ready;

    // Register memory-ready; it is high when idle and after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b1;
        end else begin
            mem_ready <= ~stall_req;
        end
    end

endmodule

// File: rtl/sndbus_data_latch.sv
// Module: sndbus_data_latch
// Captures the processor write data on a selected write. It then holds the
// byte on the generator's data pins until the next such write, so the
// generator sees stable data across its setup and hold window.
// Assumes: synchronous active-low reset clears the byte.
module sndbus_data_latch
    import sndbus_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  snd_acc_t          acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] per_data
);

    logic load_en;

    // Load only on a qualified write inside the window.
    always_comb load_en = acc.hit & acc.wr;

    // Hold register for the generator data inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_data <= '0;
        end else if (load_en) begin
            per_data <= wdata;
        end
    end

endmodule

// File: rtl/sndbus_wr_bridge.sv
// Module: sndbus_wr_bridge
// Top of the processor-bus to sound-generator write bridge. It joins the
// qualified address decoder, the strobe registers, the ready/stretch
// register and the data latch. Every output is one register away from the
// bus inputs.
// Assumes: bus inputs are stable around the rising edge of clk.
module sndbus_wr_bridge
    import sndbus_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned IGNORE_BITS = 9,
    parameter logic [ADDR_W-1:0] BASE  = 16'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_vma,
    input  logic              cpu_phi2,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              snd_ready,
    output logic              snd_ce_n,
    output logic              snd_we_n,
    output logic [DATA_W-1:0] snd_data,
    output logic              cpu_mem_ready
);

    snd_acc_t acc;

    // Qualified window decode.
    sndbus_addr_match #(
        .ADDR_W      (ADDR_W),
        .IGNORE_BITS (IGNORE_BITS),
        .BASE        (BASE)
    ) i_match (
        .addr (cpu_addr),
        .rw   (cpu_rw),
        .vma  (cpu_vma),
        .phi2 (cpu_phi2),
        .acc  (acc)
    );

    // Chip select and write strobe registers.
    sndbus_strobe_gen i_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .ce_n  (snd_ce_n),
        .we_n  (snd_we_n)
    );

    // Bus-cycle stretch toward the processor clock stage.
    sndbus_ready_stretch i_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .per_ready (snd_ready),
        .mem_ready (cpu_mem_ready)
    );

    // Write data hold register.
    sndbus_data_latch #(
        .DATA_W (DATA_W)
    ) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (cpu_wdata),
        .per_data (snd_data)
    );

endmodule

// File: rtl/sndbus_wr_bridge_chk.sv
// Module: sndbus_wr_bridge_chk
// Port-level checker for sndbus_wr_bridge, bound to every instance. The
// window is recomputed here as an arithmetic range, not as a mask.
module sndbus_wr_bridge_chk #(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned IGNORE_BITS = 9,
    parameter logic [ADDR_W-1:0] BASE  = 16'h2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic              cpu_vma,
    input logic              cpu_phi2,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              snd_ready,
    input logic              snd_ce_n,
    input logic              snd_we_n,
    input logic [DATA_W-1:0] snd_data,
    input logic              cpu_mem_ready
);

    localparam logic [ADDR_W:0] LO = {1'b0, BASE};
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'((64'd1 << IGNORE_BITS) - 64'd1);

    logic in_range;
    logic sel_now;
    logic wr_now;

    always_comb begin
        in_range = ({1'b0, cpu_addr} >= LO) && ({1'b0, cpu_addr} <= HI);
        sel_now  = in_range && cpu_vma && cpu_phi2;
        wr_now   = sel_now && !cpu_rw;
    end

    assert_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_now |=> !snd_ce_n);

    assert_qualify_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_vma && cpu_phi2) |=> snd_ce_n);

    assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_range |=> snd_ce_n);

    assert_read_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rw |=> snd_we_n);

    assert_we_inside_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_we_n |-> !snd_ce_n);

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> (snd_data == $past(cpu_wdata)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_now |=> $stable(snd_data));

    assert_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now && !snd_ready) |=> !cpu_mem_ready);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_now || snd_ready) |=> cpu_mem_ready);

endmodule

bind sndbus_wr_bridge sndbus_wr_bridge_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .IGNORE_BITS (IGNORE_BITS),
    .BASE        (BASE)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_addr      (cpu_addr),
    .cpu_rw        (cpu_rw),
    .cpu_vma       (cpu_vma),
    .cpu_phi2      (cpu_phi2),
    .cpu_wdata     (cpu_wdata),
    .snd_ready     (snd_ready),
    .snd_ce_n      (snd_ce_n),
    .snd_we_n      (snd_we_n),
    .snd_data      (snd_data),
    .cpu_mem_ready (cpu_mem_ready)
);

// File: tb/test_sndbus_wr_bridge.sv
// Directed bench for sndbus_wr_bridge. Inputs change on the falling edge.
// Outputs are read on the next falling edge, one register after the stimulus.
module test_sndbus_wr_bridge;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        cpu_rw;
    logic        cpu_vma;
    logic        cpu_phi2;
    logic [7:0]  cpu_wdata;
    logic        snd_ready;
    logic        snd_ce_n;
    logic        snd_we_n;
    logic [7:0]  snd_data;
    logic        cpu_mem_ready;

    int checks = 0;
    int errors = 0;
    logic [7:0] held;

    always #10 clk = ~clk;

    sndbus_wr_bridge i_sndbus_wr_bridge (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_addr      (cpu_addr),
        .cpu_rw        (cpu_rw),
        .cpu_vma       (cpu_vma),
        .cpu_phi2      (cpu_phi2),
        .cpu_wdata     (cpu_wdata),
        .snd_ready     (snd_ready),
        .snd_ce_n      (snd_ce_n),
        .snd_we_n      (snd_we_n),
        .snd_data      (snd_data),
        .cpu_mem_ready (cpu_mem_ready)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Present one bus state, let one rising edge pass, stop at the next falling edge.
    task automatic bus(input logic [15:0] a, input logic rw, input logic vma,
                       input logic phi2, input logic [7:0] d, input logic rdy);
        cpu_addr  = a;
        cpu_rw    = rw;
        cpu_vma   = vma;
        cpu_phi2  = phi2;
        cpu_wdata = d;
        snd_ready = rdy;
        @(negedge clk);
    endtask

    task automatic idle();
        bus(16'h0000, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic expect_outs(input string req, input logic ce, input logic we,
                               input logic [7:0] d, input logic mr);
        check(req, "snd_ce_n", {15'd0, snd_ce_n}, {15'd0, ce});
        check(req, "snd_we_n", {15'd0, snd_we_n}, {15'd0, we});
        check(req, "snd_data", {8'd0, snd_data}, {8'd0, d});
        check(req, "cpu_mem_ready", {15'd0, cpu_mem_ready}, {15'd0, mr});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        bus(16'h2000, 1'b0, 1'b1, 1'b1, 8'hEE, 1'b0);
        bus(16'h2000, 1'b0, 1'b1, 1'b1, 8'hEE, 1'b0);
        expect_outs("R1", 1'b1, 1'b1, 8'h00, 1'b1);
        rst_n = 1'b1;
        idle();
        held = 8'h00;
    endtask

    task automatic t_basic_write();
        bus(16'h2000, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b1);
        held = 8'hA5;
        expect_outs("R2/R5/R6/R8", 1'b0, 1'b0, held, 1'b1);
        idle();
        expect_outs("R8 idle", 1'b1, 1'b1, held, 1'b1);
    endtask

    task automatic t_mirrors();
        logic [15:0] addrs [3] = '{16'h21FF, 16'h2155, 16'h2001};
        for (int i = 0; i < 3; i++) begin
            bus(addrs[i], 1'b0, 1'b1, 1'b1, 8'h10 + 8'(i), 1'b1);
            held = 8'h10 + 8'(i);
            expect_outs("R2 mirror", 1'b0, 1'b0, held, 1'b1);
        end
        idle();
    endtask

    task automatic t_qualifiers();
        bus(16'h2000, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0);
        expect_outs("R3 vma low", 1'b1, 1'b1, held, 1'b1);
        bus(16'h2000, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0);
        expect_outs("R3 phi2 low", 1'b1, 1'b1, held, 1'b1);
        idle();
    endtask

    task automatic t_outside();
        logic [15:0] addrs [6] = '{16'h8000, 16'hA000, 16'h1FFF,
                                   16'h2200, 16'h0000, 16'hFFFF};
        for (int i = 0; i < 6; i++) begin
            bus(addrs[i], 1'b0, 1'b1, 1'b1, 8'hC3, 1'b0);
            expect_outs("R4 outside", 1'b1, 1'b1, held, 1'b1);
        end
        idle();
    endtask

    task automatic t_read();
        bus(16'h2010, 1'b1, 1'b1, 1'b1, 8'h77, 1'b1);
        expect_outs("R5/R6 read", 1'b0, 1'b1, held, 1'b1);
        idle();
    endtask

    task automatic t_stretch();
        for (int i = 0; i < 3; i++) begin
            bus(16'h2003, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0);
            held = 8'h5A;
            expect_outs("R7 stretch", 1'b0, 1'b0, held, 1'b0);
        end
        bus(16'h2003, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b1);
        expect_outs("R8 release", 1'b0, 1'b0, held, 1'b1);
        idle();
        expect_outs("R8 after", 1'b1, 1'b1, held, 1'b1);
    endtask

    task automatic t_reset_mid();
        bus(16'h2100, 1'b0, 1'b1, 1'b1, 8'h99, 1'b0);
        expect_outs("R7 before reset", 1'b0, 1'b0, 8'h99, 1'b0);
        rst_n = 1'b0;
        bus(16'h2100, 1'b0, 1'b1, 1'b1, 8'h99, 1'b0);
        expect_outs("R1 mid-access", 1'b1, 1'b1, 8'h00, 1'b1);
        rst_n = 1'b1;
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cpu_addr = '0; cpu_rw = 1'b1; cpu_vma = 1'b0; cpu_phi2 = 1'b0;
        cpu_wdata = '0; snd_ready = 1'b1;
        held = 8'h00;
        @(negedge clk);
        t_reset();
        t_basic_write();
        t_mirrors();
        t_qualifiers();
        t_outside();
        t_read();
        t_stretch();
        t_reset_mid();
        finish_run();
    end

endmodule